// File: doc/BRIEF.md
# Multi-Pixel Raster Timing and Colour-Bar Source

This block produces the scan timing and a test image for a 3840x2160 display that refreshes 60 times a second. It runs on a 74.25 MHz clock and delivers eight pixels on every cycle, which gives 594 Mpixel/s. The full raster is 4400x2250 pixels. Every horizontal figure therefore counts groups of eight pixels, so a whole line lasts 550 clocks. The block keeps a count of clocks within the line and a count of lines within the frame. From these two counts it decodes the active window and both sync pulses, and it fills the active window with eight equal vertical colour bars.

All outputs are registered. Each output shows the decode of the counter position held in the previous cycle. The timing figures and the pixel width are parameters, so the same logic also runs at small sizes.

Top module: `vid_timing_gen`

## Requirements
- R1: While rst_ni is low, and until the first rising clock edge after it goes high, hsync_o, vsync_o and de_o are 0 and pix_o is all zeros.
- R2: A line lasts H_TOTAL clocks (default 550). Counting the clock position from 0, hsync_o is high exactly at positions HS_FIRST..HS_LAST inclusive (default 22..33). Each output appears one clock after the position it describes.
- R3: The line count advances when the clock position wraps from H_TOTAL-1 to 0. The line count wraps from V_TOTAL-1 (default 2249) to 0, and the sequence then repeats.
- R4: vsync_o is high for every clock of lines VS_FIRST..VS_LAST inclusive (default 4..8) and low on all other lines.
- R5: de_o is high only when the clock position is in H_ACT_START..H_TOTAL-1 (default 70..549, 480 clocks) and the line is in V_ACT_START..V_TOTAL-1 (default 90..2249, 2160 lines).
- R6: Whenever de_o is low, pix_o is all zeros.
- R7: The active width is cut into eight bars of (H_TOTAL-H_ACT_START)/8 clocks each (default 60). The bar index is (position-H_ACT_START)/bar width. Index 0..7 selects white, yellow, cyan, green, magenta, red, blue, black. A colour component that is present is all ones; one that is absent is zero. In each 30-bit pixel, red sits in bits 29:20, green in 19:10 and blue in 9:0.
- R8: pix_o holds PPC pixels. Pixel k occupies bits 30k+29..30k, and during the active window all PPC pixels of a clock are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one group of PPC pixels per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable, high in the active window |
| pix_o | output | PPC*3*COMP_W (240) | Pixels, lane 0 in the least significant bits |

## Verification
Horizontal and vertical sync overlap on the lines of the vertical pulse, and there each hsync window falls inside a high vsync. A second coincidence happens at the start of the active window, where the rising edge of data enable lands in the same cycle as the first bar colour. In the same way, the last active clock of each line comes just before the line counter steps. A sweep over a shrunken raster covers many whole frames, and a run of the default raster reaches the first active lines. On every cycle both runs are compared with a model written from the requirements, so the overlap cycles and the window edges are all checked.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int unsigned NUM_BARS = 8;

  // bar index -> presence of red/green/blue; index order white..black
  function automatic logic [2:0] bar_rgb(input logic [2:0] idx);
    return {~idx[1], ~idx[2], ~idx[0]};
  endfunction
endpackage

// File: rtl/vt_counter.sv
module vt_counter #(
  parameter int unsigned LIMIT = 550,
  parameter int unsigned W     = $clog2(LIMIT)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign wrap_o = en_i && (cnt_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else if (en_i)   cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/vt_window.sv
module vt_window #(
  parameter int unsigned W  = 10,
  parameter int unsigned LO = 0,
  parameter int unsigned HI = 1
) (
  input  logic [W-1:0] cnt_i,
  output logic         in_o
);
  assign in_o = (cnt_i >= W'(LO)) && (cnt_i <= W'(HI));
endmodule

// File: rtl/vt_bar_pattern.sv
module vt_bar_pattern #(
  parameter int unsigned H_W         = 10,
  parameter int unsigned H_ACT_START = 70,
  parameter int unsigned BAR_W       = 60,
  parameter int unsigned COMP_W      = 10
) (
  input  logic [H_W-1:0]      h_cnt_i,
  output logic [3*COMP_W-1:0] pix_o
);
  import vt_pkg::*;

  logic [H_W-1:0] ofs, idx;
  logic [2:0]     rgb;

  assign ofs = h_cnt_i - H_W'(H_ACT_START);
  assign idx = ofs / H_W'(BAR_W);
  assign rgb = bar_rgb(idx[2:0]);
  assign pix_o = {{COMP_W{rgb[2]}}, {COMP_W{rgb[1]}}, {COMP_W{rgb[0]}}};
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen #(
  parameter int unsigned PPC         = 8,
  parameter int unsigned COMP_W      = 10,
  parameter int unsigned H_TOTAL     = 550,
  parameter int unsigned H_ACT_START = 70,
  parameter int unsigned HS_FIRST    = 22,
  parameter int unsigned HS_LAST     = 33,
  parameter int unsigned V_TOTAL     = 2250,
  parameter int unsigned V_ACT_START = 90,
  parameter int unsigned VS_FIRST    = 4,
  parameter int unsigned VS_LAST     = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  output logic                    hsync_o,
  output logic                    vsync_o,
  output logic                    de_o,
  output logic [PPC*3*COMP_W-1:0] pix_o
);
  localparam int unsigned H_W   = $clog2(H_TOTAL);
  localparam int unsigned V_W   = $clog2(V_TOTAL);
  localparam int unsigned PIX_W = 3 * COMP_W;
  localparam int unsigned BAR_W = (H_TOTAL - H_ACT_START) / vt_pkg::NUM_BARS;

  logic [H_W-1:0]   h_cnt;
  logic [V_W-1:0]   v_cnt;
  logic             h_wrap, v_wrap;
  logic             h_act, v_act, h_sync, v_sync;
  logic [PIX_W-1:0] lane;

  vt_counter #(.LIMIT(H_TOTAL), .W(H_W)) u_hcnt (
    .clk_i, .rst_ni, .en_i(1'b1), .cnt_o(h_cnt), .wrap_o(h_wrap));

  vt_counter #(.LIMIT(V_TOTAL), .W(V_W)) u_vcnt (
    .clk_i, .rst_ni, .en_i(h_wrap), .cnt_o(v_cnt), .wrap_o(v_wrap));

  vt_window #(.W(H_W), .LO(H_ACT_START), .HI(H_TOTAL-1)) u_hact (.cnt_i(h_cnt), .in_o(h_act));
  vt_window #(.W(V_W), .LO(V_ACT_START), .HI(V_TOTAL-1)) u_vact (.cnt_i(v_cnt), .in_o(v_act));
  vt_window #(.W(H_W), .LO(HS_FIRST),    .HI(HS_LAST))   u_hsw  (.cnt_i(h_cnt), .in_o(h_sync));
  vt_window #(.W(V_W), .LO(VS_FIRST),    .HI(VS_LAST))   u_vsw  (.cnt_i(v_cnt), .in_o(v_sync));

  vt_bar_pattern #(.H_W(H_W), .H_ACT_START(H_ACT_START), .BAR_W(BAR_W), .COMP_W(COMP_W)) u_bars (
    .h_cnt_i(h_cnt), .pix_o(lane));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      pix_o   <= '0;
    end else begin
      hsync_o <= h_sync;
      vsync_o <= v_sync;
      de_o    <= h_act && v_act;
      pix_o   <= (h_act && v_act) ? {PPC{lane}} : '0;
    end
  end
endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk #(
  parameter int unsigned PPC     = 8,
  parameter int unsigned PIX_W   = 30,
  parameter int unsigned H_W     = 10,
  parameter int unsigned V_W     = 12,
  parameter int unsigned H_TOTAL = 550,
  parameter int unsigned V_TOTAL = 2250
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 hsync_o,
  input logic                 vsync_o,
  input logic                 de_o,
  input logic [PPC*PIX_W-1:0] pix_o,
  input logic [H_W-1:0]       h_cnt,
  input logic [V_W-1:0]       v_cnt
);
  // R3
  h_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cnt == H_W'(H_TOTAL-1)) |=> (h_cnt == '0));

  // R3
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cnt == H_W'(H_TOTAL-1) && v_cnt != V_W'(V_TOTAL-1)) |=> (v_cnt == $past(v_cnt) + V_W'(1)));

  // R3
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cnt != H_W'(H_TOTAL-1)) |=> $stable(v_cnt));

  // R3
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cnt == H_W'(H_TOTAL-1) && v_cnt == V_W'(V_TOTAL-1)) |=> (v_cnt == '0));

  // R4
  vsync_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vsync_o) |-> ($past(h_cnt) == '0));

  // R5
  sync_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> !de_o);

  // R6
  blank_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (pix_o == '0));

  for (genvar k = 1; k < PPC; k++) begin : g_lane
    // R8
    lanes_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pix_o[k*PIX_W +: PIX_W] == pix_o[PIX_W-1:0]);
  end
endmodule

bind vid_timing_gen vid_timing_gen_chk #(
  .PPC(PPC), .PIX_W(PIX_W), .H_W(H_W), .V_W(V_W), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .de_o(de_o), .pix_o(pix_o), .h_cnt(h_cnt), .v_cnt(v_cnt)
);

// File: tb/vid_timing_gen_tb_top.sv
module vid_timing_gen_tb_top;
  // small raster
  localparam int S_PPC = 2, S_HT = 30, S_HA = 6, S_HS0 = 2, S_HS1 = 3;
  localparam int S_VT = 10, S_VA = 4, S_VS0 = 1, S_VS1 = 2;
  // default raster
  localparam int D_PPC = 8, D_HT = 550, D_HA = 70, D_HS0 = 22, D_HS1 = 33;
  localparam int D_VT = 2250, D_VA = 90, D_VS0 = 4, D_VS1 = 8;
  localparam int RUN_CYC = D_HT * 93;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic s_hs, s_vs, s_de, d_hs, d_vs, d_de;
  logic [S_PPC*30-1:0] s_pix;
  logic [D_PPC*30-1:0] d_pix;

  int tests = 0, fails = 0;
  bit done = 0;

  vid_timing_gen #(.PPC(S_PPC), .COMP_W(10), .H_TOTAL(S_HT), .H_ACT_START(S_HA),
    .HS_FIRST(S_HS0), .HS_LAST(S_HS1), .V_TOTAL(S_VT), .V_ACT_START(S_VA),
    .VS_FIRST(S_VS0), .VS_LAST(S_VS1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_o(s_hs), .vsync_o(s_vs), .de_o(s_de), .pix_o(s_pix));

  vid_timing_gen dut_def_i (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_o(d_hs), .vsync_o(d_vs), .de_o(d_de), .pix_o(d_pix));

  function automatic logic [29:0] exp_lane(int h, int ha, int ht);
    int bw = (ht - ha) / 8;
    int b = (h - ha) / bw;
    logic r = (b == 0 || b == 1 || b == 4 || b == 5);
    logic g = (b < 4);
    logic bl = (b == 0 || b == 2 || b == 4 || b == 6);
    return {{10{r}}, {10{g}}, {10{bl}}};
  endfunction

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_raster(string name, int h, int v, int ht, int ha, int hs0, int hs1,
                              int vt, int va, int vs0, int vs1, int ppc,
                              logic hs, logic vs, logic de, logic [255:0] pix);
    logic e_de = (h >= ha && h <= ht - 1) && (v >= va && v <= vt - 1);
    logic [255:0] e_pix = '0;
    if (e_de) for (int k = 0; k < ppc; k++) e_pix[k*30 +: 30] = exp_lane(h, ha, ht);
    chk("R2 R3", {name, " hsync"}, 256'(hs), 256'(h >= hs0 && h <= hs1));
    chk("R4", {name, " vsync"}, 256'(vs), 256'(v >= vs0 && v <= vs1));
    chk("R5", {name, " de"}, 256'(de), 256'(e_de));
    chk(e_de ? "R7 R8" : "R6", {name, " pix"}, pix, e_pix);
  endtask

  initial begin
    int sh = 0, sv = 0, dh = 0, dv = 0;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    chk("R1", "reset", 256'({s_hs, s_vs, s_de, d_hs, d_vs, d_de}), '0);
    chk("R1", "reset pix", 256'(s_pix) | 256'(d_pix), '0);
    rst_ni = 1'b1;
    chk("R1", "after release", 256'({s_hs, s_vs, s_de, d_hs, d_vs, d_de}), '0);
    for (int c = 0; c < RUN_CYC; c++) begin
      @(negedge clk);
      check_raster("small", sh, sv, S_HT, S_HA, S_HS0, S_HS1, S_VT, S_VA, S_VS0, S_VS1,
                   S_PPC, s_hs, s_vs, s_de, 256'(s_pix));
      check_raster("default", dh, dv, D_HT, D_HA, D_HS0, D_HS1, D_VT, D_VA, D_VS0, D_VS1,
                   D_PPC, d_hs, d_vs, d_de, 256'(d_pix));
      // R3: line steps on clock wrap, frame wraps after last line
      if (sh == S_HT - 1) begin sh = 0; sv = (sv == S_VT - 1) ? 0 : sv + 1; end
      else sh++;
      if (dh == D_HT - 1) begin dh = 0; dv = (dv == D_VT - 1) ? 0 : dv + 1; end
      else dh++;
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (RUN_CYC + 2000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule